// File: doc/BRIEF.md
# CPRI I/Q Receive Byte-Lane Extractor

This block sits behind the receive deframer of a CPRI link running at the lowest line rate. At that rate one basic frame is sixteen bytes, and it arrives as four consecutive 32-bit words. The block tracks where each incoming word falls inside its basic frame. It keeps a 7-bit word-position counter and an 8-bit basic-frame index for this. It then presents the word on a direct I/Q receive port together with a per-byte valid mask. Downstream sample logic uses the mask to take only the I/Q bytes. The control byte is dropped: it occupies the most significant byte lane of the first word of every basic frame.

Words are offered with a qualifying strobe, and cycles without a word do not advance the counters. A hyperframe-start pulse realigns both counters to zero. While framing lock is absent, the data and position outputs keep updating but every byte lane is flagged invalid. All outputs are registered together, one clock after the word is presented.

Top module: `cpri_iq_rx_lanes`

## Requirements
- R1: While `rst` is high, at the next clock edge all outputs become zero, and the first word after reset is at position 0 of frame index 0.
- R2: The word position of accepted words counts 0, 1, 2, 3 and then returns to 0. Cycles with `word_vld_i` low do not advance it.
- R3: For an accepted word at position 0 under lock, `iq_vld_o` is 4'b0111: bit 3 (data bits 31:24, the control byte) is invalid.
- R4: For an accepted word at positions 1, 2 or 3 under lock, `iq_vld_o` is 4'b1111.
- R5: The frame index increments when the position wraps from 3 to 0, and goes from 255 to 0.
- R6: `hf_start_i` realigns the counters. With a word present, that word takes position 0 of index 0. Without a word, the next accepted word takes position 0 of index 0.
- R7: An accepted word appears on `iq_data_o` one clock later, in the same cycle as its mask, position and index.
- R8: While `lock_i` is low, `iq_vld_o` is 4'b0000 for the cycle that follows. The counters still advance.
- R9: In the cycle after one with `word_vld_i` low, `iq_vld_o` is 4'b0000. Data, position and index hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_i | input | 1 | Framing lock from the deframer |
| hf_start_i | input | 1 | Hyperframe start, realigns the counters |
| word_vld_i | input | 1 | A received word is present on `word_i` |
| word_i | input | 32 | Received basic-frame word |
| iq_data_o | output | 32 | Registered word |
| iq_vld_o | output | 4 | Per-byte-lane valid mask, bit n covers bits 8n+7:8n |
| bf_idx_o | output | 8 | Basic-frame index of the output word |
| bf_seq_o | output | 7 | Position of the output word inside its basic frame |

## Verification
The main run feeds a long stream with a regular gap pattern (one idle cycle in seven). Word data comes from a multiplicative hash, so no value repeats and a dropped or duplicated word shows up at once. The stream runs long enough for the frame index to roll over, so it shows whether idle cycles stall the position counter and whether the index wraps. A window with lock removed separates the mask gating from the counter progress. Hyperframe pulses are placed with a word, without a word, and in mid-frame, which shows whether realignment applies to the current word or to the next one.

// File: rtl/iqx_pkg.sv
package iqx_pkg;

    // Field widths fixed by the receive frame format
    localparam int unsigned POS_IDX_W = 8;
    localparam int unsigned POS_SEQ_W = 7;

    // Defaults for the lowest line rate
    localparam int unsigned DEF_DATA_W       = 32;
    localparam int unsigned DEF_WORDS_PER_BF = 4;

    typedef struct packed {
        logic [POS_IDX_W-1:0] idx;
        logic [POS_SEQ_W-1:0] seq;
    } bf_pos_t;

    // Position of the word that follows p inside the stream
    function automatic bf_pos_t pos_advance(bf_pos_t p, int unsigned last_seq);
        bf_pos_t n;
        if (p.seq == POS_SEQ_W'(last_seq)) begin
            n.seq = '0;
            n.idx = p.idx + 1'b1;
        end else begin
            n.seq = p.seq + 1'b1;
            n.idx = p.idx;
        end
        return n;
    endfunction

endpackage

// File: rtl/iqx_seq_track.sv
module iqx_seq_track
    import iqx_pkg::*;
#(
    parameter int unsigned WORDS_PER_BF = DEF_WORDS_PER_BF
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    word_vld,
    input  logic    hf_start,
    output bf_pos_t cur_pos
);
    localparam int unsigned LAST_SEQ = WORDS_PER_BF - 1;

    bf_pos_t pos_q;
    bf_pos_t pos_d;

    always_comb begin
        cur_pos = hf_start ? '0 : pos_q;
        pos_d   = pos_q;
        if (word_vld) begin
            pos_d = pos_advance(cur_pos, LAST_SEQ);
        end else if (hf_start) begin
            pos_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assert_seq_range_R2: assert property (@(posedge clk) disable iff (rst)
        pos_q.seq < POS_SEQ_W'(WORDS_PER_BF));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!word_vld && !hf_start) |=> $stable(pos_q));

    assert_frame_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (word_vld && !hf_start && pos_q.seq == POS_SEQ_W'(LAST_SEQ))
        |=> (pos_q.seq == '0 && pos_q.idx == POS_IDX_W'($past(pos_q.idx) + 1'b1)));

    assert_hf_realign_R6: assert property (@(posedge clk) disable iff (rst)
        (hf_start && !word_vld) |=> (pos_q == '0));

endmodule

// File: rtl/iqx_lane_mask.sv
module iqx_lane_mask #(
    parameter int unsigned LANES     = 4,
    parameter int unsigned CTRL_LANE = LANES - 1
) (
    input  logic             lock,
    input  logic             word_vld,
    input  logic             first_word,
    output logic [LANES-1:0] mask
);
    logic pass;
    assign pass = lock && word_vld;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (l == CTRL_LANE) begin : g_ctrl
            assign mask[l] = pass && !first_word;
        end else begin : g_iq
            assign mask[l] = pass;
        end
    end

endmodule

// File: rtl/iqx_out_reg.sv
module iqx_out_reg
    import iqx_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic [LANES-1:0]  mask_in,
    input  bf_pos_t           pos_in,
    output logic [DATA_W-1:0] data_out,
    output logic [LANES-1:0]  mask_out,
    output bf_pos_t           pos_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_out <= '0;
            mask_out <= '0;
            pos_out  <= '0;
        end else begin
            mask_out <= mask_in;
            if (load) begin
                data_out <= data_in;
                pos_out  <= pos_in;
            end
        end
    end

endmodule

// File: rtl/cpri_iq_rx_lanes.sv
module cpri_iq_rx_lanes
    import iqx_pkg::*;
#(
    parameter int unsigned DATA_W       = DEF_DATA_W,
    parameter int unsigned WORDS_PER_BF = DEF_WORDS_PER_BF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lock_i,
    input  logic                 hf_start_i,
    input  logic                 word_vld_i,
    input  logic [DATA_W-1:0]    word_i,
    output logic [DATA_W-1:0]    iq_data_o,
    output logic [DATA_W/8-1:0]  iq_vld_o,
    output logic [POS_IDX_W-1:0] bf_idx_o,
    output logic [POS_SEQ_W-1:0] bf_seq_o
);
    localparam int unsigned LANES     = DATA_W / 8;
    localparam int unsigned CTRL_LANE = LANES - 1;

    bf_pos_t          cur_pos;
    bf_pos_t          out_pos;
    logic [LANES-1:0] lane_mask;

    iqx_seq_track #(
        .WORDS_PER_BF (WORDS_PER_BF)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .word_vld (word_vld_i),
        .hf_start (hf_start_i),
        .cur_pos  (cur_pos)
    );

    iqx_lane_mask #(
        .LANES     (LANES),
        .CTRL_LANE (CTRL_LANE)
    ) mask_i (
        .lock       (lock_i),
        .word_vld   (word_vld_i),
        .first_word (cur_pos.seq == '0),
        .mask       (lane_mask)
    );

    iqx_out_reg #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) oreg_i (
        .clk      (clk),
        .rst      (rst),
        .load     (word_vld_i),
        .data_in  (word_i),
        .mask_in  (lane_mask),
        .pos_in   (cur_pos),
        .data_out (iq_data_o),
        .mask_out (iq_vld_o),
        .pos_out  (out_pos)
    );

    assign bf_idx_o = out_pos.idx;
    assign bf_seq_o = out_pos.seq;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (iq_vld_o == '0 && iq_data_o == '0 && bf_idx_o == '0 && bf_seq_o == '0));

    assert_ctrl_lane_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (iq_vld_o != '0 && bf_seq_o == '0)
        |-> (!iq_vld_o[CTRL_LANE] && $countones(iq_vld_o) == LANES - 1));

    assert_full_lanes_R4: assert property (@(posedge clk) disable iff (rst)
        (iq_vld_o != '0 && bf_seq_o != '0) |-> (&iq_vld_o));

    assert_data_latency_R7: assert property (@(posedge clk) disable iff (rst)
        word_vld_i |=> (iq_data_o == $past(word_i)));

    assert_unlocked_mask_R8: assert property (@(posedge clk) disable iff (rst)
        !lock_i |=> (iq_vld_o == '0));

    assert_idle_mask_R9: assert property (@(posedge clk) disable iff (rst)
        !word_vld_i |=> (iq_vld_o == '0 && $stable(iq_data_o)));

endmodule

// File: tb/cpri_iq_rx_lanes_tb_top.sv
module cpri_iq_rx_lanes_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lock_i = 1'b0;
    logic        hf_start_i = 1'b0;
    logic        word_vld_i = 1'b0;
    logic [31:0] word_i = '0;
    logic [31:0] iq_data_o;
    logic [3:0]  iq_vld_o;
    logic [7:0]  bf_idx_o;
    logic [6:0]  bf_seq_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 1'b0;

    // expected model state
    int m_seq = 0;
    int m_idx = 0;
    logic [31:0] e_data = '0;
    logic [3:0]  e_mask = '0;
    int e_seq = 0;
    int e_idx = 0;
    bit saw_idx_wrap = 1'b0;

    always #5 clk = ~clk;

    cpri_iq_rx_lanes dut_i (
        .clk        (clk),
        .rst        (rst),
        .lock_i     (lock_i),
        .hf_start_i (hf_start_i),
        .word_vld_i (word_vld_i),
        .word_i     (word_i),
        .iq_data_o  (iq_data_o),
        .iq_vld_o   (iq_vld_o),
        .bf_idx_o   (bf_idx_o),
        .bf_seq_o   (bf_seq_o)
    );

    task automatic check(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, check outputs at the next one
    task automatic step(bit vld, bit hf, bit lk, logic [31:0] d);
        int cs, ci;
        word_vld_i = vld;
        hf_start_i = hf;
        lock_i     = lk;
        word_i     = d;
        cs = hf ? 0 : m_seq;
        ci = hf ? 0 : m_idx;
        if (vld) begin
            e_data = d;
            e_seq  = cs;
            e_idx  = ci;
            e_mask = !lk ? 4'b0000 : (cs == 0 ? 4'b0111 : 4'b1111);
            if (cs == 3) begin
                m_seq = 0;
                if (ci == 255) saw_idx_wrap = 1'b1;
                m_idx = (ci + 1) % 256;
            end else begin
                m_seq = cs + 1;
                m_idx = ci;
            end
        end else begin
            e_mask = 4'b0000;
            if (hf) begin
                m_seq = 0;
                m_idx = 0;
            end
        end
        @(negedge clk);
        if (!vld)
            check("R9", "idle mask", iq_vld_o, e_mask);
        else if (!lk)
            check("R8", "unlocked mask", iq_vld_o, e_mask);
        else if (e_seq == 0)
            check("R3", "first word mask", iq_vld_o, e_mask);
        else
            check("R4", "full mask", iq_vld_o, e_mask);
        check(vld ? "R7" : "R9", "data", iq_data_o, e_data);
        check(hf ? "R6" : "R2", "position", bf_seq_o, e_seq);
        check(hf ? "R6" : "R5", "frame index", bf_idx_o, e_idx);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1", "reset mask", iq_vld_o, 0);
        check("R1", "reset data", iq_data_o, 0);
        check("R1", "reset index", bf_idx_o, 0);
        check("R1", "reset position", bf_seq_o, 0);
        rst = 1'b0;
        for (int i = 0; i < 1700; i++) begin
            bit v, h, k;
            v = (i % 7) != 6;
            k = !(i >= 1450 && i < 1490);
            h = (i == 1500) || (i == 1511) || (i == 1530) || (i == 1601);
            step(v, h, k, 32'(i + 1) * 32'h9E37_79B1);
        end
        check("R5", "index rolled past 255", saw_idx_wrap, 1);
        // reset in mid-stream: the next word restarts at position 0, index 0
        rst = 1'b1;
        word_vld_i = 1'b1;
        @(negedge clk);
        check("R1", "reset mid-stream mask", iq_vld_o, 0);
        check("R1", "reset mid-stream index", bf_idx_o, 0);
        rst = 1'b0;
        m_seq = 0;
        m_idx = 0;
        e_data = '0;
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b1, 32'hA5A5_0000 + 32'(i));
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule